// File: doc/BRIEF.md
# Gated 22 kHz Tone Controller

The block derives a 22 kHz square-wave carrier from the system clock and decides when that carrier appears on the tone output. It serves one supply section. A part with two sections uses two instances. The carrier divider never stops, and the gate that lets the carrier through opens and closes only on carrier half-cycle boundaries. Every burst therefore starts and ends with whole half-cycles and keeps the divider's phase.

The carrier can pass only when the section is enabled and a transmit-arm request is present. The arm request may come from a register bit, from a pin, or from both. Once armed, the carrier is keyed by a serial modulation input, which passes through a synchroniser first. The carrier can also be forced on continuously with a separate bit. The gate opens after a delay of at most half a carrier cycle and closes one full carrier cycle after the keying stops. If keying resumes during that closing delay, the stop is cancelled.

A strobe that drives an external pull-down stage is produced during the low halves of a running tone. It stays idle at all other times.

Top module: `tone_ctrl`

## Requirements
- R1: While reset is asserted and directly after it is released, `tone_o`, `active_o` and `pdc_o` are low.
- R2: Let HALF = CLK_HZ/(2*TONE_HZ), and count rising clock edges from the first edge after reset release as edge 1. The internal carrier toggles on every edge whose number is a multiple of HALF. It is high after edge n when floor(n/HALF) is odd. While `active_o` is high, `tone_o` equals that carrier.
- R3: If `mod_i` is first sampled high at edge m, `active_o` rises at the first edge numbered a multiple of HALF that is at least m+2.
- R4: If `mod_i` is first sampled low again at edge f, `active_o` falls at the second edge numbered a multiple of HALF that is at least f+2.
- R5: If `mod_i` returns high early enough that it is seen two edges later, before that closing edge, the stop is cancelled and `active_o` stays high without a gap.
- R6: The arm condition is `arm_reg_i` OR `arm_pin_i`. If both are low, `active_o` is low from the next edge on, whatever `mod_i` and `cont_i` do.
- R7: With the section enabled and armed, a high `cont_i` opens the gate at the first HALF-multiple edge after it is sampled. This happens with `mod_i` low. When `cont_i` goes low, the gate closes by the rule of R4, applied without the two synchroniser edges.
- R8: When `en_i` is sampled low, `active_o` is low after that edge, and no tone starts while it stays low.
- R9: `pdc_o` is high exactly when `active_o` is high and the carrier is in its low half. It is never high while `active_o` is low.
- R10: When `active_o` is low, `tone_o` idles low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock (frequency CLK_HZ) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Section enable; low is stand-by |
| arm_reg_i | input | 1 | Transmit-arm request from a register bit |
| arm_pin_i | input | 1 | Transmit-arm request from a pin |
| cont_i | input | 1 | Continuous-tone request |
| mod_i | input | 1 | Asynchronous serial keying input |
| tone_o | output | 1 | Gated carrier, idles low |
| active_o | output | 1 | High while the gate lets the carrier through |
| pdc_o | output | 1 | Pull-down strobe during low carrier halves of a running tone |

## Verification
A change on the keying input, seen through the synchroniser, can fall in the same cycle as a half-cycle boundary. In that cycle the gate must both react to the keying and honour the boundary. The stimulus table places keying edges at every offset from a boundary, including the cycle just before one. The expected edge numbers for opening and closing are worked out from R3 and R4. A second collision occurs when keying resumes in the cycle in which the pending stop has already counted its first boundary. This is provoked by the cancellation row, and the bench requires `active_o` to stay high in every cycle across the gap.

// File: rtl/tone_ctrl_pkg.sv
package tone_ctrl_pkg;

    // gate controller states
    typedef enum logic [1:0] {
        GATE_OFF  = 2'd0,
        GATE_RUN  = 2'd1,
        GATE_STOP = 2'd2
    } gate_state_e;

    typedef struct packed {
        gate_state_e state;
        logic        one_seen;   // first boundary of the stop delay already passed
    } gate_reg_t;

    localparam gate_reg_t GATE_RESET = '{state: GATE_OFF, one_seen: 1'b0};

endpackage

// File: rtl/tone_divider.sv
module tone_divider #(
    parameter int unsigned HALF_CNT = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o,    // next edge is a half-cycle boundary
    output logic phase_o    // carrier level
);
    localparam int unsigned CNT_W = (HALF_CNT > 1) ? $clog2(HALF_CNT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CNT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } div_reg_t;

    div_reg_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (div_q.cnt == LAST) begin
            div_d.cnt   = '0;
            div_d.phase = ~div_q.phase;
        end else begin
            div_d.cnt = div_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign tick_o  = (div_q.cnt == LAST);
    assign phase_o = div_q.phase;

endmodule

// File: rtl/tone_sync.sv
module tone_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    localparam int unsigned DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[DEPTH-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q[DEPTH-1];

endmodule

// File: rtl/tone_gate.sv
module tone_gate
    import tone_ctrl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic arm_i,
    input  logic cont_i,
    input  logic mod_i,
    input  logic tick_i,
    output logic gate_o
);
    gate_reg_t gate_d, gate_q;
    logic      allow;
    logic      want;

    always_comb begin
        allow  = en_i & arm_i;
        want   = allow & (cont_i | mod_i);
        gate_d = gate_q;
        if (!allow) begin
            // stand-by or disarmed: close at once
            gate_d = GATE_RESET;
        end else begin
            case (gate_q.state)
                GATE_OFF: begin
                    if (want && tick_i) begin
                        gate_d.state = GATE_RUN;
                    end
                end
                GATE_RUN: begin
                    if (!want) begin
                        gate_d.state    = GATE_STOP;
                        gate_d.one_seen = tick_i;
                    end
                end
                GATE_STOP: begin
                    if (want) begin
                        gate_d.state    = GATE_RUN;
                        gate_d.one_seen = 1'b0;
                    end else if (tick_i) begin
                        if (gate_q.one_seen) begin
                            gate_d = GATE_RESET;
                        end else begin
                            gate_d.one_seen = 1'b1;
                        end
                    end
                end
                default: begin
                    gate_d = GATE_RESET;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gate_q <= GATE_RESET;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign gate_o = (gate_q.state != GATE_OFF);

endmodule

// File: rtl/tone_ctrl.sv
module tone_ctrl #(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned TONE_HZ     = 22_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic arm_reg_i,
    input  logic arm_pin_i,
    input  logic cont_i,
    input  logic mod_i,
    output logic tone_o,
    output logic active_o,
    output logic pdc_o
);
    localparam int unsigned HALF_RAW = CLK_HZ / (2 * TONE_HZ);
    localparam int unsigned HALF_CNT = (HALF_RAW < 2) ? 2 : HALF_RAW;

    logic tick;
    logic phase;
    logic mod_sync;
    logic gate;

    tone_divider #(
        .HALF_CNT (HALF_CNT)
    ) div_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_o  (tick),
        .phase_o (phase)
    );

    tone_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (mod_i),
        .sync_o  (mod_sync)
    );

    tone_gate gate_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .arm_i  (arm_reg_i | arm_pin_i),
        .cont_i (cont_i),
        .mod_i  (mod_sync),
        .tick_i (tick),
        .gate_o (gate)
    );

    assign tone_o   = gate & phase;
    assign active_o = gate;
    assign pdc_o    = gate & ~phase;

endmodule

// File: rtl/tone_ctrl_chk.sv
module tone_ctrl_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic arm_reg_i,
    input logic arm_pin_i,
    input logic tone_o,
    input logic active_o,
    input logic pdc_o
);
    // R9
    pdc_needs_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pdc_o |-> active_o);

    // R9
    pdc_tone_split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active_o |-> (tone_o ^ pdc_o));

    // R10
    idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !active_o |-> !tone_o);

    // R8
    standby_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !active_o);

    // R6
    disarm_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!arm_reg_i && !arm_pin_i) |=> !active_o);

endmodule

bind tone_ctrl tone_ctrl_chk chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .arm_reg_i (arm_reg_i),
    .arm_pin_i (arm_pin_i),
    .tone_o    (tone_o),
    .active_o  (active_o),
    .pdc_o     (pdc_o)
);

// File: tb/tone_ctrl_tb_top.sv
`timescale 1ns/1ps
module tone_ctrl_tb_top;
    localparam int HALF = 10;
    localparam int ROWS = 12;
    localparam int SPAN = 80;

    // columns: r, f, r2, f2, cont_mode, arm_sel(bit0 reg, bit1 pin), en_cut, S, E
    localparam int VEC [ROWS][9] = '{
        '{ 0, 10,  0,  0, 0, 1,  0, 10, 30},
        '{ 3, 28,  0,  0, 0, 2,  0, 10, 40},
        '{ 8, 18,  0,  0, 0, 3,  0, 10, 30},
        '{ 9, 49,  0,  0, 0, 1,  0, 20, 70},
        '{15, 28,  0,  0, 0, 2,  0, 20, 40},
        '{18, 38,  0,  0, 0, 1,  0, 20, 50},
        '{ 0, 15, 22, 32, 0, 1,  0, 10, 50},
        '{ 5, 45,  0,  0, 1, 1,  0, 10, 60},
        '{ 3, 28,  0,  0, 0, 0,  0,  0,  0},
        '{ 3, 28,  0,  0, 1, 0,  0,  0,  0},
        '{ 0, 60,  0,  0, 0, 1, 26, 10, 26},
        '{ 3, 28,  0,  0, 0, 1,  1,  0,  0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1, arm_reg = 1'b0, arm_pin = 1'b0, cont = 1'b0, mod_in = 1'b0;
    logic tone, active, pdc;
    int   ecnt = 0;
    int   n_checks = 0;
    int   n_fails = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

    tone_ctrl #(
        .CLK_HZ  (440_000),
        .TONE_HZ (22_000)
    ) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .en_i      (en),
        .arm_reg_i (arm_reg),
        .arm_pin_i (arm_pin),
        .cont_i    (cont),
        .mod_i     (mod_in),
        .tone_o    (tone),
        .active_o  (active),
        .pdc_o     (pdc)
    );

    function automatic string row_tag(int row);
        case (row)
            6:       return "R5";
            7:       return "R7";
            8, 9:    return "R6";
            10, 11:  return "R8";
            default: return "R3/R4";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic run_row(input int row, input int base);
        int  bad_a = 0, bad_t = 0, bad_p = 0;
        int  fa_act = 0, fa_exp = 0, ft_act = 0, ft_exp = 0, fp_act = 0, fp_exp = 0;
        while (ecnt < base - 1) @(negedge clk);
        arm_reg = VEC[row][5][0];
        arm_pin = VEC[row][5][1];
        while (ecnt - base <= SPAN) begin
            int rel = ecnt - base;
            bit e_act, e_tone, e_pdc, p1, p2;
            e_act  = (rel >= VEC[row][7]) && (rel < VEC[row][8]);
            e_tone = e_act && (((ecnt / HALF) % 2) == 1);
            e_pdc  = e_act && (((ecnt / HALF) % 2) == 0);
            if (active != e_act && bad_a == 0) begin fa_act = active; fa_exp = e_act; end
            if (active != e_act) bad_a++;
            if (tone != e_tone && bad_t == 0) begin ft_act = tone; ft_exp = e_tone; end
            if (tone != e_tone) bad_t++;
            if (pdc != e_pdc && bad_p == 0) begin fp_act = pdc; fp_exp = e_pdc; end
            if (pdc != e_pdc) bad_p++;
            p1 = (rel >= VEC[row][0] - 1) && (rel < VEC[row][1] - 1);
            p2 = (VEC[row][2] != VEC[row][3]) &&
                 (rel >= VEC[row][2] - 1) && (rel < VEC[row][3] - 1);
            if (VEC[row][4] != 0) cont = p1;
            else                  mod_in = p1 | p2;
            en = !((VEC[row][6] > 0) && (rel >= VEC[row][6] - 1));
            @(negedge clk);
        end
        mod_in = 1'b0;
        cont   = 1'b0;
        en     = 1'b1;
        check(bad_a == 0, row_tag(row), $sformatf("row %0d active_o", row), fa_act, fa_exp);
        // R2 and R10: carrier shape and idle level
        check(bad_t == 0, "R2/R10", $sformatf("row %0d tone_o", row), ft_act, ft_exp);
        // R9: pull-down strobe
        check(bad_p == 0, "R9", $sformatf("row %0d pdc_o", row), fp_act, fp_exp);
    endtask

    initial begin
        #(200_000 * 4);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        arm_reg = 1'b1;
        mod_in  = 1'b1;
        cont    = 1'b1;
        repeat (5) @(negedge clk);
        // R1: outputs low while in reset, even with requests present
        check(tone == 1'b0 && active == 1'b0 && pdc == 1'b0, "R1", "outputs in reset",
              {tone, active, pdc}, 0);
        arm_reg = 1'b0;
        mod_in  = 1'b0;
        cont    = 1'b0;
        rst_n   = 1'b1;
        @(negedge clk);
        // R1: outputs low directly after release
        check(tone == 1'b0 && active == 1'b0 && pdc == 1'b0, "R1", "outputs after release",
              {tone, active, pdc}, 0);
        for (int row = 0; row < ROWS; row++) begin
            run_row(row, 100 * (row + 1));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule